// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This block produces the eight register-register results of the standard integer multiply/divide extension for a 32-bit pipeline. The execute stage presents two operands, a 3-bit operation code and a valid strobe. Exactly one clock later the block returns the 32-bit result with a matching valid. There is no handshake and no stall. Every operation completes in a single cycle, using behavioural multiply and divide operators.

The three multiply-high variants are not built as separate multipliers. One unsigned 64-bit product is formed, and the signed and mixed-sign upper halves are obtained by subtracting sign corrections from its upper word. Division is done on operand magnitudes and the signs are applied afterwards. Division by zero and signed overflow give fixed architected values and raise no exception.

The control half registers the valid strobe and the operation code. The operation code is decoded into a one-hot pick vector that travels with the registered results. The datapath half registers all candidate results and selects among them with that vector.

Top module: `muldiv_unit`

## Requirements
- R1: The operation code selects 000 = low product, 001 = signed×signed high, 010 = signed×unsigned high, 011 = unsigned×unsigned high, 100 = signed quotient, 101 = unsigned quotient, 110 = signed remainder, 111 = unsigned remainder. Code 000 returns the low 32 bits of the product, which are the same for any signedness.
- R2: Code 001 returns bits 63:32 of the product of both operands read as two's-complement values.
- R3: Code 010 returns bits 63:32 of the product of opA read as signed and opB read as unsigned.
- R4: Code 011 returns bits 63:32 of the product of both operands read as unsigned.
- R5: The signed quotient (100) truncates toward zero. The signed remainder (110) takes the sign of the dividend, and dividend = quotient×divisor + remainder.
- R6: The unsigned quotient (101) and unsigned remainder (111) treat both operands as unsigned.
- R7: A zero divisor gives a quotient of 0xFFFFFFFF for both codes 100 and 101.
- R8: A zero divisor gives a remainder equal to opA for both codes 110 and 111.
- R9: A signed quotient of 0x80000000 by 0xFFFFFFFF gives 0x80000000, and the matching signed remainder gives 0.
- R10: The result that belongs to operands sampled at a clock edge is on `result` right after the next clock edge. It is selected by the operation code sampled with those operands.
- R11: `outValid` equals `inValid` delayed by one clock. A synchronous reset clears `outValid` and sets `result` to 0.
- R12: While `inValid` is low, the operands and operation code are ignored and `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and code are valid this cycle |
| funcSel | input | 3 | Operation code |
| opA | input | 32 | First operand (multiplicand / dividend) |
| opB | input | 32 | Second operand (multiplier / divisor) |
| outValid | output | 1 | Result valid, one clock after inValid |
| result | output | 32 | Selected result |

## Verification
Each operation code is driven with sign combinations that separate the three high-product variants. Only a correct signed or unsigned reading of bit 31 makes their results differ. Divisions use negative dividends and divisors with non-zero remainders to expose wrong truncation or a wrong remainder sign, and the zero-divisor and overflow cases are targeted directly. Random operands mixed with idle cycles show that the registered code stays paired with its result and that idle inputs leave the output untouched.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int OP_COUNT = 8;

  typedef enum logic [2:0] {
    OP_MUL    = 3'b000,
    OP_MULH   = 3'b001,
    OP_MULHSU = 3'b010,
    OP_MULHU  = 3'b011,
    OP_DIV    = 3'b100,
    OP_DIVU   = 3'b101,
    OP_REM    = 3'b110,
    OP_REMU   = 3'b111
  } muldiv_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                capture;  // load new operands this cycle
    logic [OP_COUNT-1:0] pick;     // one-hot select of registered result
  } muldiv_strobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [2:0]     funcSel,
  output muldiv_strobe_t strobe,
  output logic           outValid
);

  logic [2:0] funcQ;
  logic       validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      funcQ  <= OP_MUL;
      validQ <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid) funcQ <= funcSel;
    end
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.pick    = '0;
    strobe.pick[funcQ] = 1'b1;
  end

  assign outValid = validQ;

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic            clk,
  input  logic            rst,
  input  muldiv_strobe_t  strobe,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);

  localparam int PW = 2 * XLEN;

  // one unsigned product; signed highs come from corrections
  logic [PW-1:0]   prodUU;
  logic [XLEN-1:0] corrA, corrB;
  logic [XLEN-1:0] hiUU, hiSU, hiSS, lo;

  always_comb begin
    prodUU = PW'(opA) * PW'(opB);
    corrA  = opA[XLEN-1] ? opB : '0;
    corrB  = opB[XLEN-1] ? opA : '0;
    lo     = prodUU[XLEN-1:0];
    hiUU   = prodUU[PW-1:XLEN];
    hiSU   = hiUU - corrA;
    hiSS   = hiUU - corrA - corrB;
  end

  // division on magnitudes
  logic            divZero, negA, negB;
  logic [XLEN-1:0] safeB, magA, magB, safeMagB;
  logic [XLEN-1:0] magQ, magR, quoU, remU, quoS, remS;

  always_comb begin
    divZero  = (opB == '0);
    negA     = opA[XLEN-1];
    negB     = opB[XLEN-1];
    safeB    = divZero ? XLEN'(1) : opB;
    magA     = negA ? (~opA + 1'b1) : opA;
    magB     = negB ? (~opB + 1'b1) : opB;
    safeMagB = divZero ? XLEN'(1) : magB;
    magQ     = magA / safeMagB;
    magR     = magA % safeMagB;
    quoU     = divZero ? '1  : (opA / safeB);
    remU     = divZero ? opA : (opA % safeB);
    quoS     = divZero ? '1  : ((negA ^ negB) ? (~magQ + 1'b1) : magQ);
    remS     = divZero ? opA : (negA ? (~magR + 1'b1) : magR);
  end

  logic [XLEN-1:0] cand [OP_COUNT];
  logic [XLEN-1:0] next [OP_COUNT];

  always_comb begin
    next[OP_MUL]    = lo;
    next[OP_MULH]   = hiSS;
    next[OP_MULHSU] = hiSU;
    next[OP_MULHU]  = hiUU;
    next[OP_DIV]    = quoS;
    next[OP_DIVU]   = quoU;
    next[OP_REM]    = remS;
    next[OP_REMU]   = remU;
  end

  // masked AND-OR of the registered candidates
  logic [XLEN-1:0] masked [OP_COUNT];

  for (genvar k = 0; k < OP_COUNT; k++) begin : g_cand
    always_ff @(posedge clk) begin
      if (rst)                 cand[k] <= '0;
      else if (strobe.capture) cand[k] <= next[k];
    end
    assign masked[k] = strobe.pick[k] ? cand[k] : '0;
  end

  always_comb begin
    result = '0;
    for (int k = 0; k < OP_COUNT; k++) result = result | masked[k];
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [2:0]      funcSel,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            outValid,
  output logic [XLEN-1:0] result
);

  muldiv_strobe_t strobe;

  muldiv_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .funcSel  (funcSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  muldiv_datapath #(.XLEN(XLEN)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int XLEN = 32
)(
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic [2:0]      funcSel,
  input logic [XLEN-1:0] opA,
  input logic [XLEN-1:0] opB,
  input logic            outValid,
  input logic [XLEN-1:0] result
);

  localparam logic [XLEN-1:0] MINNEG = {1'b1, {(XLEN-1){1'b0}}};

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));

  assert_valid_delay_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (outValid == $past(inValid)));

  assert_low_product_R1: assert property (@(posedge clk) disable iff (rst)
    (inValid && funcSel == 3'b000) |=> (result == XLEN'($past(opA) * $past(opB))));

  assert_divzero_quot_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && funcSel[2] && !funcSel[1] && opB == '0) |=> (result == '1));

  assert_divzero_rem_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && funcSel[2] && funcSel[1] && opB == '0) |=> (result == $past(opA)));

  assert_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (inValid && funcSel == 3'b100 && opA == MINNEG && opB == '1) |=> (result == MINNEG));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !inValid) |=> $stable(result));

endmodule

bind muldiv_unit muldiv_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  funcSel = 3'b000;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  logic [31:0] expResult = '0;

  always #2.5 clk = ~clk;

  muldiv_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .funcSel(funcSel),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] refModel(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub, q;
    logic [63:0] p;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
    case (f)
      3'd0: begin p = 64'(sa * sb); return p[31:0]; end
      3'd1: begin p = 64'(sa * sb); return p[63:32]; end
      3'd2: begin p = 64'(sa * ub); return p[63:32]; end
      3'd3: begin p = 64'({32'b0, a}) * 64'({32'b0, b}); return p[63:32]; end
      3'd4: begin if (b == 0) return '1; q = sa / sb; return q[31:0]; end
      3'd5: begin if (b == 0) return '1; q = ua / ub; return q[31:0]; end
      3'd6: begin if (b == 0) return a; q = sa % sb; return q[31:0]; end
      default: begin if (b == 0) return a; q = ua % ub; return q[31:0]; end
    endcase
  endfunction

  function automatic string reqTag(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    if (b == 0 && f[2]) return f[1] ? "R8" : "R7";
    if (f == 3'd4 && a == 32'h8000_0000 && b == '1) return "R9";
    if (f == 3'd6 && a == 32'h8000_0000 && b == '1) return "R9";
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, then compare against the model after the edge
  task automatic step(input logic v, input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    string tag;
    inValid = v; funcSel = f; opA = a; opB = b;
    @(posedge clk); #1;
    if (v) begin
      expResult = refModel(f, a, b);
      tag = reqTag(f, a, b);
    end else begin
      tag = "R12";
    end
    check("R11", {31'b0, outValid}, {31'b0, v});
    check(v ? {tag, "/R10"} : tag, result, expResult);
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [31:0] pool [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                            32'h7FFF_FFFF, 32'h0000_0007, 32'hFFFF_FFF9, 32'h1234_5678};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11", {31'b0, outValid}, 32'd0);
    check("R11", result, 32'd0);
    rst = 1'b0;

    // multiply variants with sign mixes
    step(1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 3'd1, 32'h8000_0000, 32'h8000_0000);
    step(1, 3'd2, 32'h8000_0000, 32'h0000_0002);
    // signed division truncation and remainder sign
    step(1, 3'd4, 32'hFFFF_FFF9, 32'h0000_0002);
    step(1, 3'd6, 32'hFFFF_FFF9, 32'h0000_0002);
    step(1, 3'd6, 32'h0000_0007, 32'hFFFF_FFFE);
    step(1, 3'd5, 32'hFFFF_FFF9, 32'h0000_0002);
    step(1, 3'd7, 32'hFFFF_FFF9, 32'h0000_0002);
    // zero divisor on all four divide codes
    step(1, 3'd4, 32'h1234_5678, 32'h0);
    step(1, 3'd5, 32'h1234_5678, 32'h0);
    step(1, 3'd6, 32'hDEAD_BEEF, 32'h0);
    step(1, 3'd7, 32'hDEAD_BEEF, 32'h0);
    // signed overflow
    step(1, 3'd4, 32'h8000_0000, 32'hFFFF_FFFF);
    step(1, 3'd6, 32'h8000_0000, 32'hFFFF_FFFF);
    // idle cycles with busy inputs must not disturb the output
    step(0, 3'd3, 32'hFFFF_FFFF, 32'h5);
    step(0, 3'd0, 32'h0, 32'h0);

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a, b;
      a = ($urandom % 3 == 0) ? pool[$urandom % 8] : $urandom;
      b = ($urandom % 3 == 0) ? pool[$urandom % 8] : $urandom;
      if ($urandom % 8 == 0) b = 32'h0;
      step(($urandom % 5) != 0, 3'($urandom), a, b);
    end

    // reset in mid-stream clears valid and result
    inValid = 1'b1; funcSel = 3'd3; opA = '1; opB = '1;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11", {31'b0, outValid}, 32'd0);
    check("R11", result, 32'd0);
    rst = 1'b0;
    expResult = '0;
    step(1, 3'd0, 32'h0001_0000, 32'h0001_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule